// File: doc/BRIEF.md
# Gated Waveform Playback Controller

This block plays a stored waveform out of a sample memory toward a DAC. The playback is controlled by the level of a gate input. A segment is described by a start address and a length. While the synchronized gate is high and gated operation is enabled, the controller fetches the segment one word per sample clock. It restarts from the segment start without a gap at every pass boundary. When the gate drops, the pass in progress still runs to its final point. The controller then goes idle, and the output keeps showing that final point rather than returning to zero.

The memory read port has one cycle of latency. The controller issues an address in one cycle and captures the returned word on the next edge, so samples follow each other on consecutive clocks. The lowest 1K words of the 512K-word memory hold the built-in standard waveform. A select input plays that fixed region in place of the programmed segment. Segment settings are taken at the start of every pass, including a wrap.

Top module: `gated_wave_player`

## Requirements
- R1: While reset is asserted, and directly after it, `sampleValid` is 0, `sampleOut` is 0 and `active` is 0.
- R2: The gate passes through a two-flop synchronizer. When the gate is first sampled high while the block is idle, the first valid sample appears at the output after the fifth rising clock edge. That sample is the memory word at `segStart`.
- R3: Within a pass, the addresses `segStart` to `segStart+len-1` (modulo the memory size) are read one per clock. Each word appears on `sampleOut` with `sampleValid` high two clocks after its address was driven.
- R4: If the synchronized gate is still high when the last point of a pass is addressed, the next cycle addresses the segment start. `sampleValid` stays high across the boundary.
- R5: If the gate falls during a pass, the pass continues to its last point. The number of valid samples delivered is a whole multiple of the segment length.
- R6: Once idle, `sampleValid` is 0, `sampleOut` holds the last point of the final pass, and `memAddr` does not change.
- R7: When `gatedMode` is 0, the gate is treated as low. No pass starts, and a pass in progress ends at its last point.
- R8: A `segLen` of 0 or 1 is treated as a length of 2.
- R9: With `stdSel` high at the start of a pass, the pass covers addresses 0 to 1023 and ignores `segStart` and `segLen`.
- R10: `segStart`, `segLen` and `stdSel` are sampled only when a pass starts or wraps. A change during a pass applies from the next pass.
- R11: `active` is high from the first fetch cycle until the cycle in which the last fetched word is captured, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gatedMode | input | 1 | 1 = gated operation enabled; 0 = gate treated as low |
| gateIn | input | 1 | Asynchronous gate level |
| stdSel | input | 1 | Play the reserved standard-waveform region |
| segStart | input | ADDR_W (19) | Segment start address |
| segLen | input | ADDR_W+1 (20) | Segment length in samples |
| memAddr | output | ADDR_W (19) | Memory read address |
| memData | input | DATA_W (14) | Memory read data, one cycle after the address |
| sampleOut | output | DATA_W (14) | Sample toward the DAC |
| sampleValid | output | 1 | A new sample was captured this cycle |
| active | output | 1 | Playback in progress (fetching or capture pending) |

## Verification
The hardest case to reach from the ports is a gate that falls so close to a pass boundary that the synchronizer delay decides whether another full pass runs. This case is sharpest with the clamped two-sample segment, where a boundary comes every other cycle. The stimulus drops the gate at several offsets into short and long segments, and at a wrap with freshly changed segment settings. A cycle-accurate behavioural model then decides each cycle's expected output, and the final-sample and sample-count checks confirm that each pass ran to its end.

// File: rtl/gwp_pkg.sv
package gwp_pkg;
  typedef struct packed {
    logic fetch;    // an address is on memAddr this cycle
    logic passEnd;  // that address is the last point of the pass
  } gwp_strobe_t;
endpackage

// File: rtl/gwp_ctrl.sv
module gwp_ctrl import gwp_pkg::*; #(
  parameter int ADDR_W  = 19,
  parameter int STD_LEN = 1024,
  parameter int MIN_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gatedMode,
  input  logic              gateIn,
  input  logic              stdSel,
  input  logic [ADDR_W-1:0] segStart,
  input  logic [ADDR_W:0]   segLen,
  output logic [ADDR_W-1:0] memAddr,
  output logic              running,
  output gwp_strobe_t       strb
);
  localparam int LEN_W = ADDR_W + 1;

  logic gSync1, gSync2, gateOk;
  logic [ADDR_W-1:0] base, basePick;
  logic [LEN_W-1:0]  lenM1, lenPick, offset;
  logic lastPt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gSync1 <= 1'b0;
      gSync2 <= 1'b0;
    end else begin
      gSync1 <= gateIn;
      gSync2 <= gSync1;
    end
  end

  assign gateOk = gSync2 & gatedMode;

  always_comb begin
    if (stdSel) begin
      basePick = '0;
      lenPick  = LEN_W'(STD_LEN - 1);
    end else begin
      basePick = segStart;
      lenPick  = (segLen < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN - 1) : segLen - 1'b1;
    end
  end

  assign lastPt = running && (offset == lenM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      base    <= '0;
      lenM1   <= LEN_W'(MIN_LEN - 1);
      offset  <= '0;
    end else if (!running) begin
      if (gateOk) begin
        running <= 1'b1;
        base    <= basePick;
        lenM1   <= lenPick;
        offset  <= '0;
      end
    end else if (lastPt) begin
      if (gateOk) begin
        base   <= basePick;
        lenM1  <= lenPick;
        offset <= '0;
      end else begin
        running <= 1'b0;
      end
    end else begin
      offset <= offset + 1'b1;
    end
  end

  assign memAddr      = base + offset[ADDR_W-1:0];
  assign strb.fetch   = running;
  assign strb.passEnd = lastPt;

  // R3
  offset_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> offset <= lenM1);
  // R8
  min_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenM1 >= LEN_W'(MIN_LEN - 1));
  // R2
  start_at_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> offset == '0);
  // R5
  stop_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastPt && !gateOk) |=> !running);
  // R6
  idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !gateOk) |=> $stable(memAddr));
endmodule

// File: rtl/gwp_datapath.sv
module gwp_datapath import gwp_pkg::*; #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  gwp_strobe_t       strb,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid,
  output logic              busy
);
  logic capPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPend     <= 1'b0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      capPend     <= strb.fetch;
      sampleValid <= capPend;
      if (capPend) sampleOut <= memData;
    end
  end

  assign busy = capPend;

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleOut));
  // R3
  pass_end_is_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.passEnd |-> strb.fetch);
endmodule

// File: rtl/gated_wave_player.sv
module gated_wave_player import gwp_pkg::*; #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 14,
  parameter int STD_LEN = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gatedMode,
  input  logic              gateIn,
  input  logic              stdSel,
  input  logic [ADDR_W-1:0] segStart,
  input  logic [ADDR_W:0]   segLen,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid,
  output logic              active
);
  gwp_strobe_t strb;
  logic running, busy;

  gwp_ctrl #(.ADDR_W(ADDR_W), .STD_LEN(STD_LEN), .MIN_LEN(2)) uCtrl (
    .clk(clk), .rstN(rstN), .gatedMode(gatedMode), .gateIn(gateIn),
    .stdSel(stdSel), .segStart(segStart), .segLen(segLen),
    .memAddr(memAddr), .running(running), .strb(strb)
  );

  gwp_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData),
    .sampleOut(sampleOut), .sampleValid(sampleValid), .busy(busy)
  );

  assign active = running | busy;

  // R11
  active_while_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleValid) |-> $past(active));
endmodule

// File: tb/sim_gated_wave_player.sv
module sim_gated_wave_player;
  localparam int AW = 19, DW = 14, STDL = 1024;
  localparam int AMASK = (1 << AW) - 1, DMASK = (1 << DW) - 1;

  logic clk = 0, rstN = 0, gatedMode = 0, gateIn = 0, stdSel = 0;
  logic [AW-1:0] segStart = '0;
  logic [AW:0]   segLen = '0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData = '0, sampleOut;
  logic sampleValid, active;

  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  gated_wave_player u0 (.clk(clk), .rstN(rstN), .gatedMode(gatedMode), .gateIn(gateIn),
    .stdSel(stdSel), .segStart(segStart), .segLen(segLen), .memAddr(memAddr),
    .memData(memData), .sampleOut(sampleOut), .sampleValid(sampleValid), .active(active));

  function automatic int memFn(int a);
    return ((a * 37 + 11) ^ (a >> 3)) & DMASK;
  endfunction

  always @(posedge clk) memData <= DW'(memFn(int'(memAddr)));

  // Behavioural reference model
  int mBase = 0, mLenM1 = 1, mOff = 0, mOut = 0, p1d = 0, nowAddr = 0;
  bit mRun = 0, mValid = 0, p1v = 0, g1 = 0, g2 = 0, wasRun = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBase = 0; mLenM1 = 1; mOff = 0; mOut = 0; p1d = 0;
      mRun = 0; mValid = 0; p1v = 0; g1 = 0; g2 = 0;
    end else begin
      nowAddr = (mBase + mOff) & AMASK;
      wasRun = mRun;
      if (p1v) mOut = p1d;
      mValid = p1v;
      p1v = wasRun;
      p1d = memFn(nowAddr);
      if (!mRun || mOff == mLenM1) begin
        if (g2 && gatedMode) begin
          mRun = 1; mOff = 0;
          if (stdSel) begin mBase = 0; mLenM1 = STDL - 1; end
          else begin mBase = int'(segStart); mLenM1 = (int'(segLen) < 2) ? 1 : int'(segLen) - 1; end
        end else mRun = 0;
      end else mOff++;
      g2 = g1; g1 = gateIn;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison and sample tallies
  int vCount = 0;
  bit gapSeen = 0, anyValid = 0;
  always @(negedge clk) begin
    if (rstN) begin
      chk(sampleValid == mValid, "R3 sampleValid", sampleValid, mValid);
      chk(int'(sampleOut) == mOut, "R3 sampleOut", sampleOut, mOut);
      chk(active == (mRun | p1v), "R11 active", active, mRun | p1v);
      if (mRun) chk(int'(memAddr) == ((mBase + mOff) & AMASK), "R3 memAddr", memAddr, (mBase + mOff) & AMASK);
      if (sampleValid) begin vCount++; anyValid = 1; end
      else if (anyValid && gateIn && active) gapSeen = 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (active) @(negedge clk);
    waitN(2);
  endtask

  task automatic clearTally();
    vCount = 0; anyValid = 0; gapSeen = 0;
  endtask

  initial begin
    logic [DW-1:0] held;
    logic [AW-1:0] heldAddr;
    int lat;
    segStart = 19'd100; segLen = 20'd5; gatedMode = 1;
    waitN(3);
    // R1 reset state
    chk(sampleValid == 0 && active == 0, "R1 reset flags", {sampleValid, active}, 0);
    chk(sampleOut == 0, "R1 reset sample", sampleOut, 0);
    @(negedge clk) rstN = 1;
    waitN(2);
    chk(sampleValid == 0 && active == 0 && sampleOut == 0, "R1 after reset", sampleOut, 0);

    // R2 start latency, R4 wrap, R5 finish pass
    clearTally();
    gateIn = 1;
    lat = 0;
    while (!sampleValid && lat < 20) begin @(negedge clk); lat++; end
    chk(lat == 5, "R2 first sample latency", lat, 5);
    chk(int'(sampleOut) == memFn(100), "R2 first sample value", sampleOut, memFn(100));
    waitN(13);
    gateIn = 0;
    waitIdle();
    chk(!gapSeen, "R4 no gap across wrap", gapSeen, 0);
    chk(vCount % 5 == 0 && vCount >= 15, "R5 whole passes", vCount, 15);
    chk(int'(sampleOut) == memFn(104), "R5 last point", sampleOut, memFn(104));

    // R6 idle hold
    held = sampleOut; heldAddr = memAddr;
    waitN(10);
    chk(sampleOut == held && !sampleValid, "R6 hold last", sampleOut, held);
    chk(memAddr == heldAddr, "R6 address stopped", memAddr, heldAddr);

    // R8 clamp: length 0 and 1
    for (int L = 0; L < 2; L++) begin
      clearTally();
      segStart = 19'd500; segLen = 20'(L);
      gateIn = 1; waitN(4); gateIn = 0;
      waitIdle();
      chk(vCount > 0 && vCount % 2 == 0, "R8 clamp count", vCount, 2);
      chk(int'(sampleOut) == memFn(501), "R8 clamp last", sampleOut, memFn(501));
    end

    // R7 mode off: gate ignored, running pass ends
    clearTally();
    gatedMode = 0; segLen = 20'd6; gateIn = 1;
    waitN(20);
    chk(vCount == 0 && !active, "R7 no start", vCount, 0);
    gateIn = 0; waitN(3);
    gatedMode = 1; gateIn = 1; waitN(9);
    gatedMode = 0;
    waitIdle();
    gateIn = 0;
    chk(vCount % 6 == 0 && vCount > 0, "R7 pass ends", vCount, 6);
    gatedMode = 1;

    // R10 settings change mid-pass applies at wrap
    clearTally();
    segStart = 19'd200; segLen = 20'd8; gateIn = 1;
    waitN(7);
    segStart = 19'd300;
    waitN(10);
    gateIn = 0;
    waitIdle();
    chk(int'(sampleOut) == memFn(307), "R10 new base after wrap", sampleOut, memFn(307));
    chk(vCount % 8 == 0, "R10 whole passes", vCount, 16);

    // R9 standard region at address 0, wrapping segStart near top of memory
    clearTally();
    stdSel = 1; segStart = 19'h7FFFE; segLen = 20'd3;
    gateIn = 1; waitN(6); gateIn = 0;
    waitIdle();
    chk(vCount == STDL, "R9 standard length", vCount, STDL);
    chk(int'(sampleOut) == memFn(STDL - 1), "R9 standard last", sampleOut, memFn(STDL - 1));

    // R3 address modulo memory size
    clearTally();
    stdSel = 0;
    gateIn = 1; waitN(5); gateIn = 0;
    waitIdle();
    chk(int'(sampleOut) == memFn(0), "R3 address wraps memory", sampleOut, memFn(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule